// File: doc/BRIEF.md
# Calendar Real-Time Clock with Deferred Register Commit

This block keeps wall-clock time (seconds, minutes, hours) and a calendar date (day of month, month, year) and advances them once for every single-cycle one-second strobe it receives from outside. Month lengths and February in leap years are handled in hardware. The year is held as an offset from a base year whose width and base are picked by a parameter. When the offset passes its largest value, hardware works out the leap flag for the new year.

Software sees three 32-bit words on a small register port: a control word, a packed date word and a packed time word. Each read returns a word whose fields were all updated on the same clock edge. A write to the time or date word does not reach the counters at once. The value is held in a staging register, and the matching busy bit in the control word stays set until the write is committed, a fixed number of strobes later. Writes that arrive while that word is still busy are dropped.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset the time word reads 00:00:00. The date word reads day 1, month 1, year offset 0, and its leap flag is the leap status of the base year. The control word reads 0.
- R2: Reads are combinational from `addr`: 0x0 gives the control word (bit 8 = time write pending, bit 7 = date write pending), 0x4 gives the date word, 0x8 gives the time word. Any other address reads 0, unused bits read 0, and writes to 0x0 have no effect.
- R3: In the time word, seconds sit in bits [5:0], minutes in [13:8] and hours in [20:16]. Each `tick` adds one second. Without a `tick`, neither time nor date changes.
- R4: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and advance the date by one day.
- R5: In the date word, the day sits in bits [4:0] and the month (1 to 12) in bits [11:8]. The day wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, and 31 for the others apart from February. When month 12 wraps, the month goes to 1 and the year offset rises by one.
- R6: February has 28 days when the leap flag is clear and 29 when it is set.
- R7: When the year offset advances, the leap flag becomes the leap status of the new absolute year (divisible by 4, but not by 100 unless also by 400). At its largest value the year offset wraps to 0.
- R8: A write to 0x8 while bit 8 is clear sets bit 8 on the next cycle. On the COMMIT_TICKS-th `tick` after the write, the staged time is loaded in place of that second's increment, and bit 8 clears.
- R9: A write to 0x4 while bit 7 is clear sets bit 7 on the next cycle. On the COMMIT_TICKS-th `tick` after the write, the staged date, including the leap flag bit as written, is loaded and bit 7 clears.
- R10: A write to the time or date word while its busy bit is set is ignored. The value later committed is the one accepted first.
- R11: With WIDE_YEAR=0 the year offset is 6 bits at [21:16] from base 2010, and the leap flag is at bit 22. With WIDE_YEAR=1 it is 8 bits at [23:16] from base 1970, and the leap flag is at bit 24.
- R12: On a tick where a date commit coincides with a midnight carry, the committed date wins. A tick that commits the time produces no day carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |

## Verification
The bench drives the counters across the edges where a wrong constant shows at once. These are February 28 in leap and non-leap years, a 30-day month end, December 31 into a leap year, and the wrap of the largest year offset. A wrong month table or leap rule would land on the wrong day or year. The bench also lines up commits with midnight carries. A design that applied the carry after the commit would show a date one day late, and one that let a time commit carry would skip a day. A second write while busy, and a write on a tick cycle, check that the staged value and the countdown are neither overwritten nor shortened.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

   localparam int unsigned OFS_CTRL = 0;
   localparam int unsigned OFS_DATE = 4;
   localparam int unsigned OFS_TIME = 8;

   localparam int TBUSY_BIT = 8;
   localparam int DBUSY_BIT = 7;

   typedef struct packed {
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } hms_t;

   function automatic logic leap_of(input int unsigned yr);
      return ((yr % 4) == 0) && (((yr % 100) != 0) || ((yr % 400) == 0));
   endfunction

   function automatic logic [4:0] days_in(input logic [3:0] mon, input logic leap);
      logic [4:0] n;
      case (mon)
         4'd2:                      n = leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:   n = 5'd30;
         default:                   n = 5'd31;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/rtc_commit_ctl.sv
`timescale 1ns/1ps
module rtc_commit_ctl #(
   parameter int TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic req,
   output logic busy,
   output logic accept,
   output logic commit
);
   localparam int CW = $clog2(TICKS + 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   assign accept = req && !busy_q;
   assign commit = tick && busy_q && (cnt_q == CW'(1));
   assign busy   = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(TICKS);
      end else if (tick && busy_q) begin
         if (commit) busy_q <= 1'b0;
         cnt_q <= cnt_q - CW'(1);
      end
   end
endmodule

// File: rtl/rtc_time_cnt.sv
`timescale 1ns/1ps
module rtc_time_cnt
   import rtc_cal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load,
   input  hms_t load_val,
   output hms_t cur,
   output logic day_carry
);
   hms_t t_q;
   logic s_last, m_last, h_last;

   always_comb begin
      s_last    = (t_q.sec  >= 6'd59);
      m_last    = (t_q.min  >= 6'd59);
      h_last    = (t_q.hour >= 5'd23);
      day_carry = tick && !load && s_last && m_last && h_last;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_q <= '0;
      end else if (tick) begin
         if (load) begin
            t_q <= load_val;
         end else if (!s_last) begin
            t_q.sec <= t_q.sec + 6'd1;
         end else begin
            t_q.sec <= '0;
            if (!m_last) begin
               t_q.min <= t_q.min + 6'd1;
            end else begin
               t_q.min <= '0;
               t_q.hour <= h_last ? 5'd0 : t_q.hour + 5'd1;
            end
         end
      end
   end

   assign cur = t_q;
endmodule

// File: rtl/rtc_date_cnt.sv
`timescale 1ns/1ps
module rtc_date_cnt
   import rtc_cal_pkg::*;
#(
   parameter int YW   = 6,
   parameter int BASE = 2010
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          load,
   input  logic [4:0]    ld_day,
   input  logic [3:0]    ld_mon,
   input  logic [YW-1:0] ld_year,
   input  logic          ld_leap,
   output logic [4:0]    day,
   output logic [3:0]    mon,
   output logic [YW-1:0] year,
   output logic          leap
);
   localparam int unsigned BASE_U   = BASE;
   localparam logic        RST_LEAP = leap_of(BASE_U);

   logic [4:0]    day_q;
   logic [3:0]    mon_q;
   logic [YW-1:0] year_q;
   logic          leap_q;

   logic [4:0]    mlen;
   logic [YW-1:0] yr_nxt;
   logic          leap_nxt;

   always_comb begin
      mlen     = days_in(mon_q, leap_q);
      yr_nxt   = year_q + YW'(1);
      leap_nxt = leap_of(BASE_U + {{(32-YW){1'b0}}, yr_nxt});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         day_q  <= 5'd1;
         mon_q  <= 4'd1;
         year_q <= '0;
         leap_q <= RST_LEAP;
      end else if (load) begin
         day_q  <= ld_day;
         mon_q  <= ld_mon;
         year_q <= ld_year;
         leap_q <= ld_leap;
      end else if (step) begin
         if (day_q >= mlen) begin
            day_q <= 5'd1;
            if (mon_q >= 4'd12) begin
               mon_q  <= 4'd1;
               year_q <= yr_nxt;
               leap_q <= leap_nxt;
            end else begin
               mon_q <= mon_q + 4'd1;
            end
         end else begin
            day_q <= day_q + 5'd1;
         end
      end
   end

   assign day  = day_q;
   assign mon  = mon_q;
   assign year = year_q;
   assign leap = leap_q;
endmodule

// File: rtl/rtc_cal_core.sv
`timescale 1ns/1ps
module rtc_cal_core
   import rtc_cal_pkg::*;
#(
   parameter int WIDE_YEAR    = 0,
   parameter int COMMIT_TICKS = 3,
   parameter int ADDR_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata
);
   localparam int YW       = (WIDE_YEAR != 0) ? 8 : 6;
   localparam int BASE     = (WIDE_YEAR != 0) ? 1970 : 2010;
   localparam int LEAP_BIT = 16 + YW;
   localparam int NCH      = 2;   // channel 0: time word, channel 1: date word

   if (COMMIT_TICKS < 1) begin : g_bad_ticks
      $error("rtc_cal_core: COMMIT_TICKS must be at least 1");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("rtc_cal_core: ADDR_W must cover offset 0x8");
   end
   if ((WIDE_YEAR != 0) && (WIDE_YEAR != 1)) begin : g_bad_var
      $error("rtc_cal_core: WIDE_YEAR must be 0 or 1");
   end

   // register decode
   logic [NCH-1:0] req, busy, accept, commit;
   logic           sel_time, sel_date;

   assign sel_time = (addr == ADDR_W'(OFS_TIME));
   assign sel_date = (addr == ADDR_W'(OFS_DATE));
   assign req[0]   = wr_en && sel_time;
   assign req[1]   = wr_en && sel_date;

   for (genvar k = 0; k < NCH; k++) begin : g_chan
      rtc_commit_ctl #(.TICKS(COMMIT_TICKS)) u_commit (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .req    (req[k]),
         .busy   (busy[k]),
         .accept (accept[k]),
         .commit (commit[k])
      );
   end

   // staging registers
   hms_t          t_stage;
   logic [4:0]    d_stage_day;
   logic [3:0]    d_stage_mon;
   logic [YW-1:0] d_stage_year;
   logic          d_stage_leap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_stage <= '0;
      end else if (accept[0]) begin
         t_stage.sec  <= wdata[5:0];
         t_stage.min  <= wdata[13:8];
         t_stage.hour <= wdata[20:16];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_stage_day  <= 5'd1;
         d_stage_mon  <= 4'd1;
         d_stage_year <= '0;
         d_stage_leap <= 1'b0;
      end else if (accept[1]) begin
         d_stage_day  <= wdata[4:0];
         d_stage_mon  <= wdata[11:8];
         d_stage_year <= wdata[16 +: YW];
         d_stage_leap <= wdata[LEAP_BIT];
      end
   end

   // counters
   hms_t          t_cur;
   logic          day_carry;
   logic [4:0]    d_day;
   logic [3:0]    d_mon;
   logic [YW-1:0] d_year;
   logic          d_leap;

   rtc_time_cnt u_time (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .load      (commit[0]),
      .load_val  (t_stage),
      .cur       (t_cur),
      .day_carry (day_carry)
   );

   rtc_date_cnt #(.YW(YW), .BASE(BASE)) u_date (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (day_carry),
      .load    (commit[1]),
      .ld_day  (d_stage_day),
      .ld_mon  (d_stage_mon),
      .ld_year (d_stage_year),
      .ld_leap (d_stage_leap),
      .day     (d_day),
      .mon     (d_mon),
      .year    (d_year),
      .leap    (d_leap)
   );

   // word packing
   logic [31:0] time_word, date_word, ctrl_word;

   assign time_word = {11'd0, t_cur.hour, 2'd0, t_cur.min, 2'd0, t_cur.sec};

   if (WIDE_YEAR != 0) begin : g_wide
      assign date_word = {7'd0, d_leap, d_year, 4'd0, d_mon, 3'd0, d_day};
   end else begin : g_narrow
      assign date_word = {9'd0, d_leap, d_year, 4'd0, d_mon, 3'd0, d_day};
   end

   always_comb begin
      ctrl_word            = '0;
      ctrl_word[TBUSY_BIT] = busy[0];
      ctrl_word[DBUSY_BIT] = busy[1];
   end

   always_comb begin
      if (addr == ADDR_W'(OFS_CTRL))  rdata = ctrl_word;
      else if (sel_date)              rdata = date_word;
      else if (sel_time)              rdata = time_word;
      else                            rdata = '0;
   end

   logic wdata_unused;
   assign wdata_unused = ^{wdata[31:LEAP_BIT+1], wdata[15:14], wdata[7:5], wdata[15:12]};
endmodule

// File: rtl/rtc_cal_chk.sv
`timescale 1ns/1ps
module rtc_cal_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       time_word,
   input logic [31:0]       date_word,
   input logic [31:0]       ctrl_word
);
   AST_TIME_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(time_word)); // R3
   AST_DATE_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(date_word)); // R3
   AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ctrl_word[8] && time_word[5:0] < 6'd59)
      |=> time_word[5:0] == $past(time_word[5:0]) + 6'd1); // R3
   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ctrl_word[8] && time_word[5:0] == 6'd59) |=> time_word[5:0] == 6'd0); // R4
   AST_TBUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(8) && !ctrl_word[8]) |=> ctrl_word[8]); // R8
   AST_DBUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(4) && !ctrl_word[7]) |=> ctrl_word[7]); // R9
   AST_TBUSY_DROP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_word[8]) |-> $past(tick)); // R8
   AST_DBUSY_DROP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_word[7]) |-> $past(tick)); // R9
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word[8] && !tick) |=> ctrl_word[8]); // R10
endmodule

bind rtc_cal_core rtc_cal_chk #(.ADDR_W(ADDR_W)) u_rtc_cal_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .wr_en     (wr_en),
   .addr      (addr),
   .time_word (time_word),
   .date_word (date_word),
   .ctrl_word (ctrl_word)
);

// File: tb/test_rtc_cal_core.sv
`timescale 1ns/1ps
module test_rtc_cal_core;
   localparam int K   = 3;
   localparam int GAP = 4;

   logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   always #2.5 clk = ~clk;

   rtc_cal_core #(.WIDE_YEAR(0), .COMMIT_TICKS(K), .ADDR_W(4)) i_rtc_cal_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   // reference model state
   int m_s, m_m, m_h, m_d, m_mo, m_y, m_l;
   int p_s, p_m, p_h, p_d, p_mo, p_y, p_l;
   int m_tb, m_tc, m_db, m_dc;
   int n_chk = 0, n_err = 0;
   string ph = "R1";
   bit done = 0;

   function automatic int leap_yr(int y);
      return ((y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0))) ? 1 : 0;
   endfunction

   function automatic int mdays(int mo, int lp);
      if (mo == 2) return lp ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [31:0] tw(int h, int mi, int s);
      return 32'(s) | (32'(mi) << 8) | (32'(h) << 16);
   endfunction

   function automatic logic [31:0] dw(int d, int mo, int y, int lp);
      return 32'(d) | (32'(mo) << 8) | (32'(y) << 16) | (32'(lp) << 22);
   endfunction

   always @(posedge clk) begin
      int acc_t, acc_d, ct, cd, carry;
      if (!rst_n) begin
         m_s = 0; m_m = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0; m_l = leap_yr(2010);
         m_tb = 0; m_tc = 0; m_db = 0; m_dc = 0;
         p_s = 0; p_m = 0; p_h = 0; p_d = 1; p_mo = 1; p_y = 0; p_l = 0;
      end else begin
         acc_t = (wr_en && addr == 8 && !m_tb) ? 1 : 0;
         acc_d = (wr_en && addr == 4 && !m_db) ? 1 : 0;
         ct    = (tick && m_tb && m_tc == 1) ? 1 : 0;
         cd    = (tick && m_db && m_dc == 1) ? 1 : 0;
         carry = 0;
         if (tick) begin
            if (ct) begin
               m_s = p_s; m_m = p_m; m_h = p_h;
            end else begin
               m_s++;
               if (m_s >= 60) begin
                  m_s = 0; m_m++;
                  if (m_m >= 60) begin
                     m_m = 0; m_h++;
                     if (m_h >= 24) begin m_h = 0; carry = 1; end
                  end
               end
            end
            if (cd) begin
               m_d = p_d; m_mo = p_mo; m_y = p_y; m_l = p_l;
            end else if (carry) begin
               if (m_d >= mdays(m_mo, m_l)) begin
                  m_d = 1;
                  if (m_mo >= 12) begin
                     m_mo = 1;
                     m_y = (m_y + 1) % 64;
                     m_l = leap_yr(2010 + m_y);
                  end else m_mo++;
               end else m_d++;
            end
         end
         if (acc_t) begin
            p_s = int'(wdata[5:0]); p_m = int'(wdata[13:8]); p_h = int'(wdata[20:16]);
            m_tb = 1; m_tc = K;
         end else if (tick && m_tb) begin
            if (m_tc == 1) m_tb = 0;
            m_tc--;
         end
         if (acc_d) begin
            p_d = int'(wdata[4:0]); p_mo = int'(wdata[11:8]); p_y = int'(wdata[21:16]);
            p_l = int'(wdata[22]);
            m_db = 1; m_dc = K;
         end else if (tick && m_db) begin
            if (m_dc == 1) m_db = 0;
            m_dc--;
         end
      end
   end

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", ph, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      tick = 1'b0; wr_en = 1'b0;
      addr = 4'h0; #0.2; chk("ctrl word R8 R9", rdata, (32'(m_tb) << 8) | (32'(m_db) << 7));
      addr = 4'h4; #0.2; chk("date word R5 R11", rdata, dw(m_d, m_mo, m_y, m_l));
      addr = 4'h8; #0.2; chk("time word R3 R4", rdata, tw(m_h, m_m, m_s));
      addr = 4'hC; #0.2; chk("unmapped R2", rdata, 32'h0);
   endtask

   task automatic cyc(logic t, logic w, logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      compare_all();
      tick = t; wr_en = w; addr = a; wdata = d;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, 32'h0);
   endtask

   task automatic tk(int n);
      for (int i = 0; i < n; i++) begin
         cyc(1, 0, 4'h0, 32'h0);
         idle(GAP - 1);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      cyc(0, 1, a, d);
   endtask

   task automatic midnight(int d, int mo, int y, int lp, int nt);
      wr(4'h4, dw(d, mo, y, lp));
      wr(4'h8, tw(23, 59, 58));
      tk(nt);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      ph = "R1";  idle(2);
      ph = "R3 R8"; wr(4'h8, tw(0, 0, 5)); idle(1); tk(6);
      ph = "R10"; wr(4'h8, tw(1, 2, 3)); idle(1); wr(4'h8, tw(9, 9, 9));
      wr(4'h4, dw(3, 3, 3, 0)); wr(4'h4, dw(7, 7, 7, 0)); tk(5);
      ph = "R2";  wr(4'h0, 32'hFFFF_FFFF); idle(2);
      ph = "R8 write on tick"; cyc(1, 1, 4'h8, tw(10, 30, 0)); idle(3); tk(4);
      ph = "R6 leap";  midnight(28, 2, 2, 1, 6);
      wr(4'h8, tw(23, 59, 58)); tk(6);
      ph = "R6 plain"; midnight(28, 2, 1, 0, 6);
      ph = "R5 30 day"; midnight(30, 4, 5, 0, 6);
      ph = "R5 31 day"; midnight(31, 7, 5, 0, 6);
      ph = "R7 to leap"; midnight(31, 12, 1, 0, 6);
      ph = "R7 wrap"; midnight(31, 12, 63, 0, 6);
      ph = "R12 date commit at carry";
      wr(4'h8, tw(23, 59, 56)); tk(4); wr(4'h4, dw(15, 6, 3, 0)); tk(6);
      ph = "R12 time commit no carry";
      wr(4'h8, tw(23, 59, 56)); tk(3); tk(1); wr(4'h8, tw(5, 0, 0)); tk(4);
      ph = "R4 minute hour carry"; wr(4'h8, tw(4, 58, 58)); tk(8);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule